// File: doc/BRIEF.md
# Pixel-Rate Coefficient Fetch Port

This block collects one offset correction word and one gain (shading) correction word for every converted pixel of a line scan, from an external coefficient bus. Two strobes pace the transfer, one for the offset word and one for the gain word. A configuration input selects who drives them. In internal mode the block generates both strobes itself, with fixed low and high times counted in master clocks. In external mode the strobes arrive from outside and are synchronized into the master clock domain before their edges are used.

The port has two sequencing modes. In single-bus mode the offset word and then the gain word are time-multiplexed on bus A. In two-bus mode both strobes fire together: the offset word is taken from bus A and the gain word from bus B. A phase input chooses whether each word is captured at the strobe's rising edge (0°) or at its falling edge (180°). Once both words of a pixel have been captured, they are presented together to the downstream correction stage with a one-cycle pulse. They are then held until the next pair is complete.

Top module: `coef_fetch_port`

## Requirements
- R1: After reset, `off_word` and `gain_word` are 0, `pair_valid` is 0 and both strobe outputs are low.
- R2: Internal single-bus mode: a pixel start at clock edge E0 drives the offset strobe low for edges E0..E0+1 and high for E0+2..E0+4. The gain strobe then repeats that pattern from E0+5, high for E0+7..E0+9. The two strobes are never high together. The defaults are 2 low and 3 high clocks.
- R3: Internal two-bus mode: both strobes rise together at edge E0+1 and stay high for 2 clocks. The defaults are 1 low and 2 high clocks.
- R4: With phase 0 a word is sampled at the clock edge where its strobe rises. With phase 180 it is sampled at the edge where its strobe falls.
- R5: In single-bus mode both words come from `coef_a`. In two-bus mode the offset word comes from `coef_a` and the gain word from `coef_b`.
- R6: `off_word` and `gain_word` change only together, one cycle after the last word of a pixel is sampled, and `pair_valid` is high for exactly that cycle. At all other times the words hold.
- R7: A pixel start is ignored when `corr_en` or `scan_active` is low. Dropping `scan_active` during a sequence ends it at once, discards any half-captured pair, and forces the strobes low.
- R8: With `cfg_strobe_ext`=1 both output enables and both strobe outputs are low. An input strobe level first seen at edge n, after two synchronizer stages, makes the bus be sampled at edge n+2 (rising edge for phase 0, falling edge for phase 180).
- R9: In external mode, strobe edges are ignored while `scan_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strobe_ext | input | 1 | 1: strobes are inputs; 0: strobes generated internally |
| cfg_single_bus | input | 1 | 1: single shared bus; 0: two buses |
| cfg_phase180 | input | 1 | 1: capture on falling strobe edge; 0: on rising edge |
| scan_active | input | 1 | High while a line scan runs |
| pix_start | input | 1 | One-cycle pulse at each pixel conversion |
| corr_en | input | 1 | Correction enabled for the starting pixel |
| coef_a | input | 10 | Coefficient bus A (bit 0 is LSB) |
| coef_b | input | 10 | Coefficient bus B, gain words in two-bus mode |
| ostrb_in | input | 1 | External offset strobe |
| gstrb_in | input | 1 | External gain strobe |
| ostrb_out | output | 1 | Generated offset strobe |
| gstrb_out | output | 1 | Generated gain strobe |
| ostrb_oe | output | 1 | Offset strobe output enable |
| gstrb_oe | output | 1 | Gain strobe output enable |
| off_word | output | 10 | Offset word of the last complete pixel |
| gain_word | output | 10 | Gain word of the last complete pixel |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The bench changes both buses on every clock, so sampling one edge early or late produces a wrong word. This exposes a swapped capture phase, a miscounted low or high time, or a missing synchronizer stage. Two-bus mode is run with different contents on the two buses, so a gain word taken from the wrong bus shows up as a mismatch. Aborting a scan halfway and then running a full pixel catches a design that keeps the stale half-pair and presents it one pixel early. Starts with correction disabled, and external edges arriving outside a scan, must produce no pulse and leave the words unchanged.

// File: rtl/coef_fetch_pkg.sv
package coef_fetch_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_A_LOW,
      SQ_A_HIGH,
      SQ_B_LOW,
      SQ_B_HIGH
   } seq_state_e;

   typedef struct packed {
      logic off_cap;
      logic gain_cap;
   } cap_req_t;
endpackage

// File: rtl/cfp_strobe_seq.sv
module cfp_strobe_seq
   import coef_fetch_pkg::*;
#(
   parameter int LOW_1BUS  = 2,
   parameter int HIGH_1BUS = 3,
   parameter int LOW_2BUS  = 1,
   parameter int HIGH_2BUS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic run,
   input  logic single,
   output logic off_strb,
   output logic gain_strb,
   output logic off_rise,
   output logic off_fall,
   output logic gain_rise,
   output logic gain_fall
);
   localparam int MAXLEN = (LOW_1BUS > HIGH_1BUS ? LOW_1BUS : HIGH_1BUS) >
                           (LOW_2BUS > HIGH_2BUS ? LOW_2BUS : HIGH_2BUS) ?
                           (LOW_1BUS > HIGH_1BUS ? LOW_1BUS : HIGH_1BUS) :
                           (LOW_2BUS > HIGH_2BUS ? LOW_2BUS : HIGH_2BUS);
   localparam int CNTW = $clog2(MAXLEN + 1);
   localparam logic [CNTW-1:0] LO1 = CNTW'(LOW_1BUS - 1);
   localparam logic [CNTW-1:0] HI1 = CNTW'(HIGH_1BUS - 1);
   localparam logic [CNTW-1:0] LO2 = CNTW'(LOW_2BUS - 1);
   localparam logic [CNTW-1:0] HI2 = CNTW'(HIGH_2BUS - 1);

   if (LOW_1BUS < 1 || HIGH_1BUS < 1 || LOW_2BUS < 1 || HIGH_2BUS < 1) begin : g_chk
      $error("cfp_strobe_seq: strobe low/high times must be at least one clock");
   end

   seq_state_e       st_q;
   logic [CNTW-1:0]  cnt_q;
   logic             last;
   logic [CNTW-1:0]  lo_len, hi_len;

   assign last   = (cnt_q == '0);
   assign lo_len = single ? LO1 : LO2;
   assign hi_len = single ? HI1 : HI2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else if (!run) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SQ_IDLE: if (go) begin
               st_q  <= SQ_A_LOW;
               cnt_q <= lo_len;
            end
            SQ_A_LOW: if (last) begin
               st_q  <= SQ_A_HIGH;
               cnt_q <= hi_len;
            end else cnt_q <= cnt_q - 1'b1;
            SQ_A_HIGH: if (last) begin
               st_q  <= single ? SQ_B_LOW : SQ_IDLE;
               cnt_q <= single ? lo_len : '0;
            end else cnt_q <= cnt_q - 1'b1;
            SQ_B_LOW: if (last) begin
               st_q  <= SQ_B_HIGH;
               cnt_q <= hi_len;
            end else cnt_q <= cnt_q - 1'b1;
            SQ_B_HIGH: if (last) begin
               st_q  <= SQ_IDLE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q - 1'b1;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign off_strb  = (st_q == SQ_A_HIGH);
   assign gain_strb = single ? (st_q == SQ_B_HIGH) : (st_q == SQ_A_HIGH);
   assign off_rise  = run && (st_q == SQ_A_LOW)  && last;
   assign off_fall  = run && (st_q == SQ_A_HIGH) && last;
   assign gain_rise = single ? (run && (st_q == SQ_B_LOW)  && last) : off_rise;
   assign gain_fall = single ? (run && (st_q == SQ_B_HIGH) && last) : off_fall;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!off_strb && !gain_strb)); // R7
   AST_SINGLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      single |-> !(off_strb && gain_strb)); // R2
   AST_DUAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !single |-> (off_strb == gain_strb)); // R3
endmodule

// File: rtl/cfp_edge_sync.sv
module cfp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic en,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_chk
      $error("cfp_edge_sync: at least two synchronizer stages required");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], raw};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = en &&  sync_q[STAGES-1] && !prev_q;
   assign fall = en && !sync_q[STAGES-1] &&  prev_q;

   AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R8
endmodule

// File: rtl/cfp_pair_latch.sv
module cfp_pair_latch #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         cap_off,
   input  logic         cap_gain,
   input  logic [W-1:0] off_src,
   input  logic [W-1:0] gain_src,
   output logic [W-1:0] off_word,
   output logic [W-1:0] gain_word,
   output logic         pair_valid
);
   logic         have_off, have_gain;
   logic [W-1:0] off_hold, gain_hold;
   logic [W-1:0] off_nx, gain_nx;
   logic         done;

   assign off_nx  = cap_off  ? off_src  : off_hold;
   assign gain_nx = cap_gain ? gain_src : gain_hold;
   assign done    = (cap_off || cap_gain) && (have_off || cap_off) && (have_gain || cap_gain);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_off   <= 1'b0;
         have_gain  <= 1'b0;
         off_hold   <= '0;
         gain_hold  <= '0;
         off_word   <= '0;
         gain_word  <= '0;
         pair_valid <= 1'b0;
      end else if (clear) begin
         have_off   <= 1'b0;
         have_gain  <= 1'b0;
         pair_valid <= 1'b0;
      end else begin
         pair_valid <= done;
         off_hold   <= off_nx;
         gain_hold  <= gain_nx;
         if (done) begin
            off_word  <= off_nx;
            gain_word <= gain_nx;
            have_off  <= 1'b0;
            have_gain <= 1'b0;
         end else begin
            have_off  <= have_off  || cap_off;
            have_gain <= have_gain || cap_gain;
         end
      end
   end

   AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid); // R6
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_valid |-> ($stable(off_word) && $stable(gain_word))); // R6
endmodule

// File: rtl/coef_fetch_port.sv
module coef_fetch_port
   import coef_fetch_pkg::*;
#(
   parameter int COEF_W    = 10,
   parameter int LOW_1BUS  = 2,
   parameter int HIGH_1BUS = 3,
   parameter int LOW_2BUS  = 1,
   parameter int HIGH_2BUS = 2,
   parameter int SYNC_STG  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_strobe_ext,
   input  logic              cfg_single_bus,
   input  logic              cfg_phase180,
   input  logic              scan_active,
   input  logic              pix_start,
   input  logic              corr_en,
   input  logic [COEF_W-1:0] coef_a,
   input  logic [COEF_W-1:0] coef_b,
   input  logic              ostrb_in,
   input  logic              gstrb_in,
   output logic              ostrb_out,
   output logic              gstrb_out,
   output logic              ostrb_oe,
   output logic              gstrb_oe,
   output logic [COEF_W-1:0] off_word,
   output logic [COEF_W-1:0] gain_word,
   output logic              pair_valid
);
   if (COEF_W < 1) begin : g_chk
      $error("coef_fetch_port: coefficient width must be positive");
   end

   logic     i_off_s, i_gain_s, i_or, i_of, i_gr, i_gf;
   logic     go, ext_en;
   logic [1:0] x_rise, x_fall, x_raw;
   cap_req_t req;

   assign go     = pix_start && corr_en && scan_active && !cfg_strobe_ext;
   assign ext_en = scan_active && cfg_strobe_ext;

   cfp_strobe_seq #(
      .LOW_1BUS(LOW_1BUS), .HIGH_1BUS(HIGH_1BUS),
      .LOW_2BUS(LOW_2BUS), .HIGH_2BUS(HIGH_2BUS)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go),
      .run(scan_active && !cfg_strobe_ext), .single(cfg_single_bus),
      .off_strb(i_off_s), .gain_strb(i_gain_s),
      .off_rise(i_or), .off_fall(i_of), .gain_rise(i_gr), .gain_fall(i_gf)
   );

   assign x_raw = {gstrb_in, ostrb_in};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      cfp_edge_sync #(.STAGES(SYNC_STG)) u_sync (
         .clk(clk), .rst_n(rst_n), .raw(x_raw[g]), .en(ext_en),
         .rise(x_rise[g]), .fall(x_fall[g])
      );
   end

   always_comb begin
      if (cfg_strobe_ext) begin
         req.off_cap  = cfg_phase180 ? x_fall[0] : x_rise[0];
         req.gain_cap = cfg_phase180 ? x_fall[1] : x_rise[1];
      end else begin
         req.off_cap  = cfg_phase180 ? i_of : i_or;
         req.gain_cap = cfg_phase180 ? i_gf : i_gr;
      end
   end

   cfp_pair_latch #(.W(COEF_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .clear(!scan_active),
      .cap_off(req.off_cap), .cap_gain(req.gain_cap),
      .off_src(coef_a), .gain_src(cfg_single_bus ? coef_a : coef_b),
      .off_word(off_word), .gain_word(gain_word), .pair_valid(pair_valid)
   );

   assign ostrb_out = !cfg_strobe_ext && i_off_s;
   assign gstrb_out = !cfg_strobe_ext && i_gain_s;
   assign ostrb_oe  = !cfg_strobe_ext;
   assign gstrb_oe  = !cfg_strobe_ext;

   AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_strobe_ext && $past(cfg_strobe_ext)) |-> (!ostrb_out && !gstrb_out && !ostrb_oe)); // R8
endmodule

// File: tb/sim_coef_fetch_port.sv
module sim_coef_fetch_port;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_ext = 0, cfg_single = 1, cfg_ph = 0, scan = 0, pstart = 0, cen = 1;
   logic [9:0] bus_a = '0, bus_b = '0;
   logic oin = 0, gin = 0;
   logic oout, gout, ooe, goe, pv;
   logic [9:0] offw, gainw;
   int ec = 0;
   int n_run = 0, n_fail = 0;
   logic [19:0] exp_q[$];

   always #10 clk = ~clk;

   coef_fetch_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_strobe_ext(cfg_ext), .cfg_single_bus(cfg_single),
      .cfg_phase180(cfg_ph), .scan_active(scan), .pix_start(pstart), .corr_en(cen),
      .coef_a(bus_a), .coef_b(bus_b), .ostrb_in(oin), .gstrb_in(gin),
      .ostrb_out(oout), .gstrb_out(gout), .ostrb_oe(ooe), .gstrb_oe(goe),
      .off_word(offw), .gain_word(gainw), .pair_valid(pv)
   );

   function automatic logic [9:0] fa(int n); return 10'((n * 7) % 1024); endfunction
   function automatic logic [9:0] fb(int n); return 10'((n * 13 + 5) % 1024); endfunction

   always @(posedge clk) ec <= ec + 1;
   always @(negedge clk) begin
      bus_a <= fa(ec + 1);
      bus_b <= fb(ec + 1);
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && pv) begin
         if (exp_q.size() == 0) check(0, "R6 unexpected pair", {offw, gainw}, 0);
         else begin
            logic [19:0] e;
            e = exp_q.pop_front();
            check({offw, gainw} == e, "R4/R5/R6 pair", {offw, gainw}, e);
         end
      end
   end

   // internal pixel: drive start, check strobe shape, push expected pair
   task automatic int_pixel(input bit single, input bit ph);
      int e0, lo, hi, tot;
      bit ok;
      logic [9:0] eo, eg;
      lo = single ? 2 : 1;
      hi = single ? 3 : 2;
      tot = single ? 2 * (lo + hi) : lo + hi;
      @(negedge clk);
      pstart = 1;
      e0 = ec + 1;
      eo = fa(e0 + lo + (ph ? hi : 0));
      if (single) eg = fa(e0 + 2 * lo + hi + (ph ? hi : 0));
      else        eg = fb(e0 + lo + (ph ? hi : 0));
      exp_q.push_back({eo, eg});
      @(negedge clk);
      pstart = 0;
      ok = 1;
      for (int k = 0; k <= tot + 1; k++) begin
         bit eoff, egn;
         eoff = (k >= lo) && (k < lo + hi);
         egn  = single ? ((k >= 2 * lo + hi) && (k < 2 * (lo + hi))) : eoff;
         if (oout !== eoff || gout !== egn) ok = 0;
         @(negedge clk);
      end
      check(ok, single ? "R2 single-bus strobe shape" : "R3 two-bus strobe shape",
            {oout, gout}, 0);
   endtask

   // external pixel: both strobes toggled together
   task automatic ext_pixel(input bit single, input bit ph);
      int n, m;
      @(negedge clk);
      oin = 1; gin = 1;
      n = ec + 1;
      repeat (3) @(negedge clk);
      oin = 0; gin = 0;
      m = ec + 1;
      if (!ph) exp_q.push_back({fa(n + 2), single ? fa(n + 2) : fb(n + 2)});
      else     exp_q.push_back({fa(m + 2), single ? fa(m + 2) : fb(m + 2)});
      repeat (5) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [19:0] snap;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(offw == 0 && gainw == 0, "R1 words after reset", {offw, gainw}, 0);
      check(!pv && !oout && !gout, "R1 valid/strobes after reset", {pv, oout, gout}, 0);
      scan = 1;
      @(negedge clk);
      // R2 / R4 phase 0, single bus
      int_pixel(1, 0);
      int_pixel(1, 0);
      // R4 phase 180, single bus
      cfg_ph = 1;
      int_pixel(1, 1);
      // R3 / R5 two-bus, both phases
      cfg_single = 0; cfg_ph = 0;
      int_pixel(0, 0);
      cfg_ph = 1;
      int_pixel(0, 1);
      cfg_single = 1; cfg_ph = 0;
      check(exp_q.size() == 0, "R6 all internal pairs presented", exp_q.size(), 0);
      // R7 corr_en low: start ignored
      snap = {offw, gainw};
      seen = 0;
      @(negedge clk);
      cen = 0; pstart = 1;
      @(negedge clk);
      pstart = 0; cen = 1;
      repeat (12) begin
         if (oout || gout || pv) seen = 1;
         @(negedge clk);
      end
      check(!seen && {offw, gainw} == snap, "R7 start ignored when corr_en low", seen, 0);
      // R7 scan low: start ignored
      scan = 0;
      @(negedge clk);
      pstart = 1;
      @(negedge clk);
      pstart = 0;
      repeat (12) begin
         if (oout || gout || pv) seen = 1;
         @(negedge clk);
      end
      check(!seen && {offw, gainw} == snap, "R7 start ignored outside scan", seen, 0);
      // R7 abort mid-sequence then a full pixel
      scan = 1;
      @(negedge clk);
      pstart = 1;
      @(negedge clk);
      pstart = 0;
      repeat (5) @(negedge clk);   // offset word already captured
      scan = 0;
      @(negedge clk);
      @(negedge clk);
      check(!oout && !gout, "R7 strobes low after abort", {oout, gout}, 0);
      repeat (10) begin
         if (pv) seen = 1;
         @(negedge clk);
      end
      check(!seen && {offw, gainw} == snap, "R7 aborted pair discarded", {offw, gainw}, snap);
      scan = 1;
      @(negedge clk);
      int_pixel(1, 0);
      // R8 external mode
      cfg_ext = 1;
      @(negedge clk);
      check(!ooe && !goe && !oout && !gout, "R8 external direction", {ooe, goe, oout, gout}, 0);
      ext_pixel(1, 0);
      cfg_ph = 1;
      ext_pixel(1, 1);
      cfg_single = 0;
      ext_pixel(0, 1);
      cfg_ph = 0;
      ext_pixel(0, 0);
      check(exp_q.size() == 0, "R8 external pairs presented", exp_q.size(), 0);
      // R9 external edges outside scan ignored
      snap = {offw, gainw};
      scan = 0;
      @(negedge clk);
      oin = 1; gin = 1;
      repeat (4) @(negedge clk);
      oin = 0; gin = 0;
      repeat (6) begin
         if (pv) seen = 1;
         @(negedge clk);
      end
      check(!seen && {offw, gainw} == snap, "R9 edges ignored outside scan", {offw, gainw}, snap);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule